// File: doc/BRIEF.md
# Clock Control Register

This block is one 32-bit memory-mapped control word for the clock tree of a small system. Software uses it to switch on a low-speed internal oscillator, a high-speed internal oscillator, a high-speed external oscillator and a PLL. It also uses it to pick a range code for the low-speed oscillator, a divide-by-two for the system clock when the external oscillator drives it, and the function of a shared package pin. Hardware puts the synchronized ready or lock indication of each source into the same word, so one read shows both the request and its result.

Writes take effect on the next clock edge with no wait states. Each byte lane has its own strobe. Two interlocks guard the writes. The PLL cannot be switched off by software while it drives the system clock. The pin function is frozen while the external oscillator is enabled or reports ready. A low-power-entry request is granted one cycle later, provided no bus access is under way. In the same cycle as the grant, the PLL enable is cleared by hardware.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset the word reads 0x0000_0061: low-speed enable (bit 0) is 1, range (bits 7:4) is 6, every other bit is 0, and lp_gnt_o is 0.
- R2: A write (bus_req_i and bus_we_i high) changes only the fields in byte lanes whose bus_be_i bit is set. Lane k covers bits 8k+7:8k. The new value reads back in the cycle after the write edge.
- R3: Reserved bits 31:26, 23:22, 19:18, 15:11, 9 and 3:2 read as 0. Writes to them, and to the ready bits, have no effect.
- R4: Ready bits mirror their inputs two clock edges after a change: bit 1 from lso_rdy_i, bit 10 from hsi_rdy_i, bit 17 from hse_rdy_i, bit 25 from pll_lock_i.
- R5: PLL enable (bit 24) is software read/write. A write of 0 to it is ignored while sysclk_sel_i is 3 (PLL source). Setting it is always accepted.
- R6: Pin select (bit 21) accepts a write only when external oscillator enable (bit 16) and its ready bit (bit 17) both read 0 before the write edge.
- R7: sys_div2_o equals bit 20 when sysclk_sel_i is 2 (external source) and is 0 for source codes 0, 1 and 3.
- R8: When lp_req_i is high and bus_req_i is low at an edge, lp_gnt_o is 1 after that edge and the PLL enable reads 0.
- R9: At an edge where bus_req_i is high, or lp_req_i is low, lp_gnt_o goes to 0, and the PLL enable is not cleared by hardware.
- R10: The range field (bits 7:4), the internal high-speed enable (bit 8), the external enable (bit 16) and the low-speed enable (bit 0) are plain read/write fields. They drive lso_range_o, hsi_en_o, hse_en_o and lso_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | Access is a write |
| bus_be_i | input | 4 | Byte-lane write strobes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Current register value |
| lso_rdy_i | input | 1 | Low-speed oscillator ready (asynchronous) |
| hsi_rdy_i | input | 1 | Internal high-speed oscillator ready (asynchronous) |
| hse_rdy_i | input | 1 | External oscillator ready (asynchronous) |
| pll_lock_i | input | 1 | PLL lock (asynchronous) |
| sysclk_sel_i | input | 2 | System clock source: 0 low-speed, 1 internal high, 2 external, 3 PLL |
| lp_req_i | input | 1 | Low-power-entry request |
| lso_en_o | output | 1 | Low-speed oscillator enable |
| lso_range_o | output | 4 | Low-speed oscillator range code |
| hsi_en_o | output | 1 | Internal high-speed oscillator enable |
| hse_en_o | output | 1 | External oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| sys_div2_o | output | 1 | Divide system clock by two |
| pin_sel_o | output | 1 | Shared pin function select |
| lp_gnt_o | output | 1 | Low-power-entry grant |

## Verification
The assertions assume that the ready and lock inputs hold their value for whole clock cycles. They also assume that bus_be_i, bus_wdata_i and sysclk_sel_i are stable around the sampling edge, because the interlocks and the grant are judged on the values present at that edge. The stimulus changes every input only at the falling clock edge. It draws the ready inputs and the source selector at random, so that the interlocks are tried with each source and with each oscillator state. Requests for low-power entry are mixed with bus reads and writes in the same cycles, which exercises both the deferral of the grant and the hardware clear of the PLL enable.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_RDY    = 4;
  localparam int unsigned RDY_LSO  = 0;
  localparam int unsigned RDY_HSI  = 1;
  localparam int unsigned RDY_HSE  = 2;
  localparam int unsigned RDY_PLL  = 3;

  localparam int unsigned B_LSO_EN  = 0;
  localparam int unsigned B_LSO_RDY = 1;
  localparam int unsigned B_RNG_LO  = 4;
  localparam int unsigned RNG_W     = 4;
  localparam int unsigned B_HSI_EN  = 8;
  localparam int unsigned B_HSI_RDY = 10;
  localparam int unsigned B_HSE_EN  = 16;
  localparam int unsigned B_HSE_RDY = 17;
  localparam int unsigned B_DIV2    = 20;
  localparam int unsigned B_PIN     = 21;
  localparam int unsigned B_PLL_EN  = 24;
  localparam int unsigned B_PLL_RDY = 25;

  typedef enum logic [1:0] {
    SRC_LSO = 2'd0,
    SRC_HSI = 2'd1,
    SRC_HSE = 2'd2,
    SRC_PLL = 2'd3
  } src_e;

  typedef struct packed {
    logic             pll_en;
    logic             pin_sel;
    logic             div2;
    logic             hse_en;
    logic             hsi_en;
    logic [RNG_W-1:0] rng;
    logic             lso_en;
  } ctl_t;

  localparam ctl_t CTL_RST = '{pll_en: 1'b0, pin_sel: 1'b0, div2: 1'b0,
                               hse_en: 1'b0, hsi_en: 1'b0, rng: 4'd6,
                               lso_en: 1'b1};
endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ccr_wlogic.sv
module ccr_wlogic
  import ccr_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  localparam int unsigned NB = DW / 8
) (
  input  ctl_t          cur_i,
  input  logic          wr_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hse_rdy_i,
  input  logic [1:0]    src_i,
  output ctl_t          nxt_o
);
  logic [NB-1:0] lane_wr;
  logic          pll_wval;
  logic          pin_open;
  logic          unused_wdata;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane_wr[k] = wr_i & be_i[k];
  end

  assign unused_wdata = ^{wdata_i[DW-1:B_PLL_EN+1], wdata_i[B_PLL_EN-1:B_PIN+1],
                          wdata_i[B_DIV2-1:B_HSE_EN+1], wdata_i[B_HSE_EN-1:B_HSI_EN+1],
                          wdata_i[B_RNG_LO-1:B_LSO_EN+1]};

  assign pll_wval = wdata_i[B_PLL_EN];
  assign pin_open = ~cur_i.hse_en & ~hse_rdy_i;

  always_comb begin
    nxt_o = cur_i;
    if (lane_wr[B_LSO_EN/8]) nxt_o.lso_en = wdata_i[B_LSO_EN];
    if (lane_wr[B_RNG_LO/8]) nxt_o.rng    = wdata_i[B_RNG_LO +: RNG_W];
    if (lane_wr[B_HSI_EN/8]) nxt_o.hsi_en = wdata_i[B_HSI_EN];
    if (lane_wr[B_HSE_EN/8]) nxt_o.hse_en = wdata_i[B_HSE_EN];
    if (lane_wr[B_DIV2/8])   nxt_o.div2   = wdata_i[B_DIV2];
    if (lane_wr[B_PIN/8] && pin_open) nxt_o.pin_sel = wdata_i[B_PIN];
    if (lane_wr[B_PLL_EN/8]) begin
      if (pll_wval || src_e'(src_i) != SRC_PLL) nxt_o.pll_en = pll_wval;
    end
  end
endmodule

// File: rtl/ccr_lp.sv
module ccr_lp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_req_i,
  input  logic bus_busy_i,
  output logic enter_o,
  output logic gnt_o
);
  assign enter_o = lp_req_i & ~bus_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_o <= 1'b0;
    else gnt_o <= enter_o;
  end
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
  import ccr_pkg::*;
#(
  parameter int unsigned DW          = WORD_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [NB-1:0] bus_be_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          lso_rdy_i,
  input  logic          hsi_rdy_i,
  input  logic          hse_rdy_i,
  input  logic          pll_lock_i,
  input  logic [1:0]    sysclk_sel_i,
  input  logic          lp_req_i,
  output logic          lso_en_o,
  output logic [3:0]    lso_range_o,
  output logic          hsi_en_o,
  output logic          hse_en_o,
  output logic          pll_en_o,
  output logic          sys_div2_o,
  output logic          pin_sel_o,
  output logic          lp_gnt_o
);
  ctl_t             ctl_q, ctl_wr, ctl_d;
  logic [N_RDY-1:0] rdy_raw, rdy_s;
  logic             lp_enter;

  assign rdy_raw[RDY_LSO] = lso_rdy_i;
  assign rdy_raw[RDY_HSI] = hsi_rdy_i;
  assign rdy_raw[RDY_HSE] = hse_rdy_i;
  assign rdy_raw[RDY_PLL] = pll_lock_i;

  ccr_sync #(.WIDTH(N_RDY), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rdy_raw),
    .q_o   (rdy_s)
  );

  ccr_wlogic #(.DW(DW)) u_wlogic (
    .cur_i    (ctl_q),
    .wr_i     (bus_req_i & bus_we_i),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .hse_rdy_i(rdy_s[RDY_HSE]),
    .src_i    (sysclk_sel_i),
    .nxt_o    (ctl_wr)
  );

  ccr_lp u_lp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lp_req_i  (lp_req_i),
    .bus_busy_i(bus_req_i),
    .enter_o   (lp_enter),
    .gnt_o     (lp_gnt_o)
  );

  // hardware clear on low-power entry; never coincides with a write
  always_comb begin
    ctl_d = ctl_wr;
    if (lp_enter) ctl_d.pll_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RST;
    else ctl_q <= ctl_d;
  end

  always_comb begin
    bus_rdata_o = '0;
    bus_rdata_o[B_LSO_EN]               = ctl_q.lso_en;
    bus_rdata_o[B_LSO_RDY]              = rdy_s[RDY_LSO];
    bus_rdata_o[B_RNG_LO +: RNG_W]      = ctl_q.rng;
    bus_rdata_o[B_HSI_EN]               = ctl_q.hsi_en;
    bus_rdata_o[B_HSI_RDY]              = rdy_s[RDY_HSI];
    bus_rdata_o[B_HSE_EN]               = ctl_q.hse_en;
    bus_rdata_o[B_HSE_RDY]              = rdy_s[RDY_HSE];
    bus_rdata_o[B_DIV2]                 = ctl_q.div2;
    bus_rdata_o[B_PIN]                  = ctl_q.pin_sel;
    bus_rdata_o[B_PLL_EN]               = ctl_q.pll_en;
    bus_rdata_o[B_PLL_RDY]              = rdy_s[RDY_PLL];
  end

  assign lso_en_o    = ctl_q.lso_en;
  assign lso_range_o = ctl_q.rng;
  assign hsi_en_o    = ctl_q.hsi_en;
  assign hse_en_o    = ctl_q.hse_en;
  assign pll_en_o    = ctl_q.pll_en;
  assign pin_sel_o   = ctl_q.pin_sel;
  assign sys_div2_o  = ctl_q.div2 & (src_e'(sysclk_sel_i) == SRC_HSE);
endmodule

// File: rtl/clk_ctrl_reg_chk.sv
module clk_ctrl_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_req_i,
  input logic        bus_we_i,
  input logic [3:0]  bus_be_i,
  input logic [31:0] bus_wdata_i,
  input logic [31:0] bus_rdata_o,
  input logic        pll_lock_i,
  input logic [1:0]  sysclk_sel_i,
  input logic        lp_req_i,
  input logic        pll_en_o,
  input logic        pin_sel_o,
  input logic        hse_en_o,
  input logic        sys_div2_o,
  input logic        lp_gnt_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o & 32'hFCCC_FA0C) == 32'h0);  // R3

  AST_PLL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sysclk_sel_i == 2'd3 && pll_en_o && !(lp_req_i && !bus_req_i)) |=> pll_en_o);  // R5

  AST_PIN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hse_en_o || bus_rdata_o[17]) |=> $stable(pin_sel_o));  // R6

  AST_DIV2_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sysclk_sel_i != 2'd2) |-> !sys_div2_o);  // R7

  AST_GNT_PLL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_gnt_o |-> !pll_en_o);  // R8

  AST_GNT_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i || !lp_req_i) |=> !lp_gnt_o);  // R9

  AST_LOCK_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (bus_rdata_o[25] == $past(pll_lock_i, 2)));  // R4

  AST_NOWR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i) |=> ($stable(pin_sel_o) && $stable(hse_en_o)));  // R2
endmodule

bind clk_ctrl_reg clk_ctrl_reg_chk u_chk (.*);

// File: tb/tb_clk_ctrl_reg.sv
`timescale 1ns/1ps
module tb_clk_ctrl_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [3:0]  bus_be_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        lso_rdy_i = 1'b0, hsi_rdy_i = 1'b0, hse_rdy_i = 1'b0, pll_lock_i = 1'b0;
  logic [1:0]  sysclk_sel_i = '0;
  logic        lp_req_i = 1'b0;
  logic        lso_en_o, hsi_en_o, hse_en_o, pll_en_o, sys_div2_o, pin_sel_o, lp_gnt_o;
  logic [3:0]  lso_range_o;

  always #4 clk_i = ~clk_i;

  clk_ctrl_reg dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic       m_lso, m_hsi, m_hse, m_div2, m_pin, m_pll, m_gnt;
  logic [3:0] m_rng, s1, s2;

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[0] = m_lso; w[1] = s2[0]; w[7:4] = m_rng; w[8] = m_hsi; w[10] = s2[1];
    w[16] = m_hse; w[17] = s2[2]; w[20] = m_div2; w[21] = m_pin;
    w[24] = m_pll; w[25] = s2[3];
    return w;
  endfunction

  function automatic logic [11:0] exp_out();
    return {m_lso, m_rng, m_hsi, m_hse, m_pll, m_div2 & (sysclk_sel_i == 2'd2), m_pin, m_gnt, 1'b0};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lso = 1; m_rng = 4'd6; m_hsi = 0; m_hse = 0; m_div2 = 0; m_pin = 0;
    m_pll = 0; m_gnt = 0; s1 = '0; s2 = '0;
  endtask

  task automatic step(string tag, logic req, logic we, logic [3:0] be, logic [31:0] wd,
                      logic [1:0] sel, logic lpr, logic [3:0] rdy);
    logic wr, enter, pin_open;
    @(negedge clk_i);
    bus_req_i = req; bus_we_i = we; bus_be_i = be; bus_wdata_i = wd;
    sysclk_sel_i = sel; lp_req_i = lpr;
    {pll_lock_i, hse_rdy_i, hsi_rdy_i, lso_rdy_i} = rdy;
    @(posedge clk_i);
    wr = req & we; enter = lpr & ~req; pin_open = ~m_hse & ~s2[2];
    if (wr && be[2] && pin_open) m_pin = wd[21];
    if (wr && be[0]) begin m_lso = wd[0]; m_rng = wd[7:4]; end
    if (wr && be[1]) m_hsi = wd[8];
    if (wr && be[2]) begin m_hse = wd[16]; m_div2 = wd[20]; end
    if (wr && be[3] && (wd[24] || sel != 2'd3)) m_pll = wd[24];
    if (enter) m_pll = 0;
    m_gnt = enter;
    s2 = s1; s1 = rdy;
    #1;
    chk(tag, {bus_rdata_o, 20'd0,
              lso_en_o, lso_range_o, hsi_en_o, hse_en_o, pll_en_o, sys_div2_o, pin_sel_o, lp_gnt_o, 1'b0},
             {exp_word(), 20'd0, exp_out()});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk("R1 reset word", {32'd0, bus_rdata_o}, 64'h61);
    chk("R1 reset outs", {63'd0, lp_gnt_o}, 64'd0);

    step("R3 all ones write", 1, 1, 4'hF, 32'hFFFF_FFFF, 2'd0, 0, 4'h0);
    chk("R3 literal", {32'd0, bus_rdata_o}, 64'h0131_01F1);
    step("R5 R6 clear under pll", 1, 1, 4'hF, 32'h0, 2'd3, 0, 4'h0);
    chk("R5 literal", {32'd0, bus_rdata_o}, 64'h0120_0000);
    step("R7 div2 set", 1, 1, 4'b0100, 32'h0010_0000, 2'd2, 0, 4'h0);
    chk("R7 div2 on", {63'd0, sys_div2_o}, 64'd1);
    step("R7 other src", 0, 0, 4'h0, 32'h0, 2'd1, 0, 4'h0);
    chk("R7 div2 off", {63'd0, sys_div2_o}, 64'd0);
    step("R4 lock edge1", 0, 0, 4'h0, 32'h0, 2'd0, 0, 4'h8);
    chk("R4 not yet", {63'd0, bus_rdata_o[25]}, 64'd0);
    step("R4 lock edge2", 0, 0, 4'h0, 32'h0, 2'd0, 0, 4'h8);
    chk("R4 mirrored", {63'd0, bus_rdata_o[25]}, 64'd1);
    step("R5 set pll", 1, 1, 4'b1000, 32'h0100_0000, 2'd3, 0, 4'h8);
    step("R9 lp with bus", 1, 0, 4'h0, 32'h0, 2'd3, 1, 4'h8);
    chk("R9 no grant", {62'd0, lp_gnt_o, pll_en_o}, 64'd1);
    step("R8 lp grant", 0, 0, 4'h0, 32'h0, 2'd3, 1, 4'h8);
    chk("R8 grant clr", {62'd0, lp_gnt_o, pll_en_o}, 64'd2);
    step("R9 req drop", 0, 0, 4'h0, 32'h0, 2'd0, 0, 4'h8);
    chk("R9 grant off", {63'd0, lp_gnt_o}, 64'd0);
    step("R2 lane0 only", 1, 1, 4'b0001, 32'hFFFF_FFA0, 2'd0, 0, 4'h0);
    chk("R10 range", {60'd0, lso_range_o}, 64'hA);
    step("R6 hse off", 1, 1, 4'b0100, 32'h0, 2'd0, 0, 4'h0);
    step("R6 pin write", 1, 1, 4'b0100, 32'h0020_0000, 2'd0, 0, 4'h0);
    chk("R6 pin open", {63'd0, pin_sel_o}, 64'd1);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rdy;
      rdy = (($urandom % 4) == 0) ? 4'($urandom) : {pll_lock_i, hse_rdy_i, hsi_rdy_i, lso_rdy_i};
      step("R2 random", ($urandom % 2) == 0, ($urandom % 10) < 7, 4'($urandom), $urandom,
           2'($urandom), ($urandom % 5) == 0, rdy);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule